// File: doc/BRIEF.md
# Two-Channel Interrupt Status and Mask Unit

This block is the shared interrupt front end of a two-channel serial controller. Each channel presents two level conditions: its transmitter is ready for another character, and its receiver holds a character. The unit packs these into a status byte in which every channel owns one nibble. The host reads that byte at register address 5. A host write to the same address does not change the status. It loads a separate enable mask, which has the same bit layout and cannot be read back.

A single active-low interrupt request is driven from a register. It is low whenever any status bit is set together with its mask bit. The host therefore sees a falling edge when a new enabled source becomes active. Reset clears the mask, so nothing is requested until software enables a source.

Two bits of every nibble are spare positions for optional sources, such as a counter/timer, input change or break change. A parameter decides whether the spare inputs reach the status byte. With the default setting they are tied off. The ready conditions themselves are produced elsewhere.

Top module: `irq_hub`

## Requirements
- R1: A read with `bus_addr` equal to 5 returns the status byte on `rd_data`. Any other address returns zero.
- R2: Within the status byte, channel n places its transmitter-ready level at bit 4n and its receiver-ready level at bit 4n+1. For two channels these are bits 0, 1, 4 and 5.
- R3: A write (`bus_wr` high) with `bus_addr` equal to 5 loads `wr_data` into the mask at the clock edge. Mask bit k enables status bit k. A write to any other address leaves the mask unchanged, and so does address 5 with `bus_wr` low.
- R4: The mask is write-only. Reading address 5 shows only the status byte, whatever the mask holds.
- R5: `irq_n` is a registered output. After each rising edge it equals the inverse of the OR-reduction of (status AND mask) as sampled at that edge. A change in mask or status therefore shows on `irq_n` only after the following edge, and a mask write appears two edges after its own cycle.
- R6: While reset is asserted and after it is released, the mask is all zeros and `irq_n` is high. Ready inputs alone never pull `irq_n` low until a mask bit is written.
- R7: Status bits are live levels, not latched. A bit reads zero as soon as its ready input falls, with no clear action by the host.
- R8: With the default `SPARE_EN` of 0, the spare positions (bits 2, 3, 6 and 7) read zero. The `spare_src` inputs then have no effect on `rd_data` or `irq_n`, even with every mask bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register address for the read and write |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| wr_data | input | 4*NUM_CH (8) | Write data, loaded into the mask |
| rd_data | output | 4*NUM_CH (8) | Read data, combinational from the address |
| tx_rdy | input | NUM_CH (2) | Per-channel transmitter-ready level |
| rx_rdy | input | NUM_CH (2) | Per-channel receiver-ready level |
| spare_src | input | 2*NUM_CH (4) | Optional sources for the two spare bits of each nibble |
| irq_n | output | 1 | Active-low interrupt request, registered |

## Verification
The read path has no register, so `rd_data` is due in the same cycle that the address and the ready levels are applied. The bench samples it one time unit after driving its inputs on the falling edge.

`irq_n` is due one edge after a status change and two edges after a mask write. The bench therefore checks it after each of those edges. After the write edge it expects the old mask ANDed with the new status, and after the next edge it expects the new mask. This pins the latency exactly rather than only the final value.

The sweep covers every ready pattern against every mask byte. Ignored writes and spare inputs are judged from `irq_n` and `rd_data` after the edges at which they could have acted.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int unsigned NIBBLE_W = 4;
    localparam int unsigned TX_OFS   = 0;
    localparam int unsigned RX_OFS   = 1;
    localparam int unsigned SPARE_OFS = 2;
    localparam int unsigned SPARE_PER_CH = 2;

    function automatic int unsigned tx_bit(input int unsigned ch);
        return ch * NIBBLE_W + TX_OFS;
    endfunction

    function automatic int unsigned rx_bit(input int unsigned ch);
        return ch * NIBBLE_W + RX_OFS;
    endfunction
endpackage

// File: rtl/irq_stat_collect.sv
module irq_stat_collect
    import irq_hub_pkg::*;
#(
    parameter int unsigned NUM_CH   = 2,
    parameter bit          SPARE_EN = 1'b0,
    localparam int unsigned DATA_W  = NUM_CH * NIBBLE_W,
    localparam int unsigned SPARE_W = NUM_CH * SPARE_PER_CH
) (
    input  logic [NUM_CH-1:0]  tx_rdy,
    input  logic [NUM_CH-1:0]  rx_rdy,
    input  logic [SPARE_W-1:0] spare_src,
    output logic [DATA_W-1:0]  stat
);
    localparam logic [SPARE_PER_CH-1:0] SPARE_GATE = {SPARE_PER_CH{SPARE_EN}};

    // One nibble per channel; spare pair is gated by the build option.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_nib
        assign stat[tx_bit(ch)] = tx_rdy[ch];
        assign stat[rx_bit(ch)] = rx_rdy[ch];
        assign stat[ch*NIBBLE_W+SPARE_OFS +: SPARE_PER_CH] =
            spare_src[ch*SPARE_PER_CH +: SPARE_PER_CH] & SPARE_GATE;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned STAT_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mask
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STAT_ADDR);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
    } mreg_t;

    mreg_t st_d, st_q;
    logic  wr_hit;

    always_comb begin
        wr_hit = bus_wr && (bus_addr == HIT_ADDR);
        st_d   = st_q;
        if (wr_hit) begin
            st_d.mask = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.mask;

    p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == HIT_ADDR) |=> (mask == $past(wr_data)));

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == HIT_ADDR) |=> $stable(mask));
endmodule

// File: rtl/irq_req_out.sv
module irq_req_out #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] stat,
    input  logic [DATA_W-1:0] mask,
    output logic              irq_n
);
    typedef struct packed {
        logic irq_n;
    } oreg_t;

    oreg_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.irq_n = ~|(stat & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{irq_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = st_q.irq_n;

    p_irq_assert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat & mask)) |=> !irq_n);

    p_irq_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat & mask)) |=> irq_n);

    p_quiet_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> irq_n);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned NUM_CH    = 2,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned STAT_ADDR = 5,
    parameter bit          SPARE_EN  = 1'b0,
    localparam int unsigned DATA_W   = NUM_CH * NIBBLE_W,
    localparam int unsigned SPARE_W  = NUM_CH * SPARE_PER_CH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_CH-1:0]  tx_rdy,
    input  logic [NUM_CH-1:0]  rx_rdy,
    input  logic [SPARE_W-1:0] spare_src,
    output logic               irq_n
);
    localparam logic [ADDR_W-1:0] RD_ADDR = ADDR_W'(STAT_ADDR);

    logic [DATA_W-1:0] stat;
    logic [DATA_W-1:0] mask;

    irq_stat_collect #(
        .NUM_CH   (NUM_CH),
        .SPARE_EN (SPARE_EN)
    ) u_stat (
        .tx_rdy    (tx_rdy),
        .rx_rdy    (rx_rdy),
        .spare_src (spare_src),
        .stat      (stat)
    );

    irq_mask_reg #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR)
    ) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .wr_data  (wr_data),
        .mask     (mask)
    );

    irq_req_out #(
        .DATA_W (DATA_W)
    ) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (stat),
        .mask  (mask),
        .irq_n (irq_n)
    );

    // Status is read-only at the shared address; the mask never reaches the read path.
    always_comb begin
        rd_data = '0;
        if (bus_addr == RD_ADDR) begin
            rd_data = stat;
        end
    end
endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int DW  = 8;
    localparam int AW  = 4;
    localparam int SA  = 5;

    logic          clk;
    logic          rst_n;
    logic [AW-1:0] bus_addr;
    logic          bus_wr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic [NCH-1:0] tx_rdy;
    logic [NCH-1:0] rx_rdy;
    logic [3:0]    spare_src;
    logic          irq_n;

    int n_cmp = 0;
    int n_bad = 0;

    irq_hub u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .tx_rdy    (tx_rdy),
        .rx_rdy    (rx_rdy),
        .spare_src (spare_src),
        .irq_n     (irq_n)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Expected status byte: tx of channel n at bit 4n, rx at bit 4n+1.
    function automatic logic [7:0] exp_stat(input logic [1:0] tx, input logic [1:0] rx);
        logic [7:0] v = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            v[4*ch]   = tx[ch];
            v[4*ch+1] = rx[ch];
        end
        return v;
    endfunction

    function automatic logic [7:0] exp_irq(input logic [7:0] s, input logic [7:0] m);
        return {7'd0, ((s & m) == 8'd0)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] mask_cur;
        logic [7:0] st;
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; wr_data = '0;
        tx_rdy = '0; rx_rdy = '0; spare_src = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 irq_n in reset", {7'd0, irq_n}, 8'h01);
        bus_addr = AW'(SA);
        #1 check("R1 status at reset idle", rd_data, 8'h00);

        // Sources active while mask is cleared by reset
        @(negedge clk);
        tx_rdy = 2'b11; rx_rdy = 2'b11;
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R6 no request with reset mask", {7'd0, irq_n}, 8'h01);
        check("R2 all ready sources", rd_data, 8'h33);

        // Exhaustive sweep: every mask byte against every ready pattern
        mask_cur = 8'h00;
        for (int m = 0; m < 256; m++) begin
            for (int s = 0; s < 16; s++) begin
                @(negedge clk);
                tx_rdy    = {s[2], s[0]};
                rx_rdy    = {s[3], s[1]};
                spare_src = 4'($urandom);
                bus_addr  = AW'(SA);
                bus_wr    = 1'b1;
                wr_data   = 8'(m);
                st = exp_stat({s[2], s[0]}, {s[3], s[1]});
                #1 check("R2 R4 R7 status read", rd_data, st);
                @(posedge clk);
                #1 check("R5 irq one edge after status", {7'd0, irq_n}, exp_irq(st, mask_cur));
                mask_cur = 8'(m);
                @(negedge clk);
                bus_wr = 1'b0;
                @(posedge clk);
                #1 check("R3 R5 irq after mask load", {7'd0, irq_n}, exp_irq(st, mask_cur));
            end
        end

        // Other addresses read zero
        @(negedge clk);
        tx_rdy = 2'b11; rx_rdy = 2'b11;
        for (int a = 0; a < 16; a++) begin
            bus_addr = AW'(a);
            #1 check("R1 read decode", rd_data, (a == SA) ? 8'h33 : 8'h00);
        end

        // Clear mask, then attempt ignored writes
        @(negedge clk);
        bus_addr = AW'(SA); bus_wr = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        bus_addr = AW'(3); wr_data = 8'hFF;
        @(negedge clk);
        bus_addr = AW'(SA); bus_wr = 1'b0; wr_data = 8'hFF;
        repeat (2) @(posedge clk);
        #1 check("R3 stray writes ignored", {7'd0, irq_n}, 8'h01);

        // Spare inputs ignored with full mask
        @(negedge clk);
        tx_rdy = '0; rx_rdy = '0; spare_src = 4'hF;
        bus_wr = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check("R8 spare bits read zero", rd_data, 8'h00);
        repeat (2) @(posedge clk);
        #1 check("R8 spare sources no request", {7'd0, irq_n}, 8'h01);

        // Live clear: receiver of channel 1 asserts then drops
        @(negedge clk);
        rx_rdy = 2'b10;
        #1 check("R7 bit 5 set", rd_data, 8'h20);
        @(posedge clk);
        #1 check("R5 request from rx1", {7'd0, irq_n}, 8'h00);
        @(negedge clk);
        rx_rdy = 2'b00;
        #1 check("R7 bit 5 cleared live", rd_data, 8'h00);
        @(posedge clk);
        #1 check("R7 request released", {7'd0, irq_n}, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule